// File: doc/BRIEF.md
# NAND page read pointer sequencer

This block is the device-side read front end of a small-page NAND memory. It watches the command-latch, address-latch, write, read and chip-enable strobes, decodes the three read-area commands, takes one column byte and one row byte, and keeps a column pointer over a 528-byte page. The page holds 512 main bytes at columns 0 to 511 and a 16-byte spare area at columns 512 to 527. After each page load it holds the active-low ready/busy output low for a fixed number of clock cycles. It then places one byte on the I/O bus for each read strobe.

A read keeps going past the end of a page without any new address. At column 527 the sequencer moves to the next page. It goes busy again for the load, then goes on at column 0 for a main-area read or at column 512 for a spare-area read. The cells are modelled by a computed pattern, so no memory is needed. All strobes are sampled on the system clock, and the sequencer acts on the edges it finds in them.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, ry_by_n is 1, io_oe is 0 and io_out is 8'h00.
- R2: Command 8'h00 followed by column byte C and row byte P starts the read at column C of page P mod 4. The byte for page p, column c is (c[7:0] + 37*c[9:8] + 101*p) mod 256.
- R3: Command 8'h01 followed by column byte C starts the read at column 256+C.
- R4: Command 8'h50 followed by column byte C starts the read at column 512+C[3:0]. Bits C[7:4] have no effect.
- R5: The spare-area selection of 8'h50 stays in force for later address sequences given without a command, including after a chip-enable cycle. A later 8'h00 or 8'h01 command returns addressing to the main area.
- R6: A byte is driven, with io_oe high, after a falling edge on re_n. The column pointer moves up by one after the rising edge. After column 527 the read goes on in the next page (page 3 wraps to page 0).
- R7: A read started by 8'h01 goes on at column 0 of the next page once column 527 is passed. From then on it behaves as an 8'h00 read.
- R8: A read started by 8'h50 goes on at column 512 of the next page once column 527 is passed.
- R9: The last address byte and each page change drive ry_by_n low for exactly TR clock cycles. While busy, io_oe is 0 and re_n pulses do not move the pointer.
- R10: With ce_n high, the sequencer is idle: io_oe is 0, ry_by_n is 1 and re_n pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all strobes are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| cle | input | 1 | Command latch enable, high during a command byte |
| ale | input | 1 | Address latch enable, high during an address byte |
| we_n | input | 1 | Active-low write strobe; bytes are latched on its rising edge |
| re_n | input | 1 | Active-low read strobe |
| io_in | input | 8 | Command and address byte input |
| io_out | output | 8 | Read data byte |
| io_oe | output | 1 | High while io_out is being driven |
| ry_by_n | output | 1 | Ready (1) or busy (0) |

## Verification
The bench goes after the page boundary in three modes. An 8'h01 read started at column 511 must go busy after column 527 and then resume at column 0. A design that kept the upper-half offset would resume at 256. A spare read started at 526 must resume at 512, not at 0. The bench checks that bits 7 to 4 of a spare column are dropped and that the spare lock survives chip enable going high, where a design that cleared it would start in the main area. It also pulses re_n during busy and with chip enable high, where a design that counted those pulses would return a byte from a later column. Random mixes of commands, columns and pages follow.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam int COL_W = 10;
    localparam logic [COL_W-1:0] LAST_COL   = 10'd527;
    localparam logic [COL_W-1:0] SPARE_BASE = 10'd512;
    localparam logic [COL_W-1:0] HALF_BASE  = 10'd256;

    localparam logic [7:0] OP_LOW   = 8'h00;
    localparam logic [7:0] OP_HIGH  = 8'h01;
    localparam logic [7:0] OP_SPARE = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BUSY,
        ST_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        AREA_LOW,
        AREA_HIGH,
        AREA_SPARE
    } area_e;

    function automatic logic [COL_W-1:0] first_col(area_e a, logic [7:0] b);
        logic [COL_W-1:0] c;
        case (a)
            AREA_HIGH:  c = HALF_BASE + {2'b00, b};
            AREA_SPARE: c = SPARE_BASE + {6'b0, b[3:0]};
            default:    c = {2'b00, b};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;
    logic [N-1:0] prev_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            prev_d[i] = strobe_n[i];
            rise[i]   = ~prev_q[i] & strobe_n[i];
            fall[i]   = prev_q[i] & ~strobe_n[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_rd_pkg::*;
(
    input  logic [7:0] code,
    output logic       known,
    output area_e      area
);
    always_comb begin
        known = 1'b1;
        area  = AREA_LOW;
        case (code)
            OP_LOW:   area = AREA_LOW;
            OP_HIGH:  area = AREA_HIGH;
            OP_SPARE: area = AREA_SPARE;
            default:  known = 1'b0;
        endcase
    end
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array
    import nand_rd_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    output logic [7:0]        data
);
    logic [7:0] hi_part;
    logic [7:0] pg_part;

    always_comb begin
        hi_part = 8'(col[9:8]) * 8'd37;
        pg_part = 8'(page) * 8'd101;
        data    = col[7:0] + hi_part + pg_part;
    end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int TR     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       ry_by_n
);
    localparam int TR_W = (TR < 2) ? 1 : $clog2(TR);
    localparam logic [TR_W-1:0] TR_INIT = TR_W'(TR - 1);

    typedef struct packed {
        seq_state_e        st;
        area_e             area;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [TR_W-1:0]   tr;
        logic              row_next;
        logic [7:0]        dout;
        logic              oe;
    } regs_t;

    regs_t q, d;

    logic [1:0] s_rise, s_fall;
    logic       we_rise, re_rise, re_fall;
    logic       dec_known;
    area_e      dec_area;
    logic [7:0] cell_byte;

    nand_strobe_edge #(.N(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({re_n, we_n}),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign we_rise = s_rise[0];
    assign re_rise = s_rise[1];
    assign re_fall = s_fall[1];

    nand_cmd_decode u_dec (
        .code  (io_in),
        .known (dec_known),
        .area  (dec_area)
    );

    nand_cell_array #(.PAGE_W(PAGE_W)) u_cells (
        .page (q.page),
        .col  (q.col),
        .data (cell_byte)
    );

    always_comb begin
        d = q;
        if (ce_n) begin
            d.st = ST_IDLE;
        end else if (we_rise && cle && q.st != ST_BUSY) begin
            if (dec_known) begin
                d.area     = dec_area;
                d.st       = ST_ADDR;
                d.row_next = 1'b0;
            end
        end else if (we_rise && ale && q.st != ST_BUSY) begin
            if (q.st == ST_ADDR && q.row_next) begin
                d.page = io_in[PAGE_W-1:0];
                d.st   = ST_BUSY;
                d.tr   = TR_INIT;
            end else begin
                d.col      = first_col(q.area, io_in);
                d.row_next = 1'b1;
                d.st       = ST_ADDR;
            end
        end else begin
            case (q.st)
                ST_BUSY: begin
                    if (q.tr == '0) d.st = ST_READ;
                    else            d.tr = q.tr - 1'b1;
                end
                ST_READ: begin
                    if (re_fall) begin
                        d.dout = cell_byte;
                        d.oe   = 1'b1;
                    end else if (re_rise) begin
                        d.oe = 1'b0;
                        if (q.col == LAST_COL) begin
                            d.page = q.page + 1'b1;
                            d.col  = (q.area == AREA_SPARE) ? SPARE_BASE : '0;
                            if (q.area == AREA_HIGH) d.area = AREA_LOW;
                            d.st = ST_BUSY;
                            d.tr = TR_INIT;
                        end else begin
                            d.col = q.col + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (d.st != ST_READ) d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.area     <= AREA_LOW;
            q.page     <= '0;
            q.col      <= '0;
            q.tr       <= '0;
            q.row_next <= 1'b0;
            q.dout     <= 8'h00;
            q.oe       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign io_out  = q.dout;
    assign io_oe   = q.oe;
    assign ry_by_n = (q.st != ST_BUSY);
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk #(
    parameter int TR = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic re_n,
    input logic io_oe,
    input logic ry_by_n
);
    int   run_q;
    logic cut_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
            cut_q <= 1'b0;
        end else if (!ry_by_n) begin
            run_q <= run_q + 1;
            if (ce_n) cut_q <= 1'b1;
        end else begin
            run_q <= 0;
            cut_q <= 1'b0;
        end
    end

    // R9: a busy period never lasts longer than TR cycles
    p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ry_by_n |-> run_q < TR);

    // R9: a busy period that chip enable did not cut lasts exactly TR cycles
    p_busy_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ry_by_n) && !cut_q) |-> run_q == TR);

    // R9: no data is driven during a page load
    p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ry_by_n |-> !io_oe);

    // R10: chip enable high leaves the sequencer idle
    p_ce_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!io_oe && ry_by_n));

    // R6: data is driven only after the read strobe went low
    p_oe_needs_re_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> !$past(re_n));
endmodule

bind nand_page_reader nand_page_reader_chk #(.TR(TR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .re_n    (re_n),
    .io_oe   (io_oe),
    .ry_by_n (ry_by_n)
);

// File: tb/nand_page_reader_test.sv
`timescale 1ns/1ps
module nand_page_reader_test;
    localparam int TRB   = 6;
    localparam int PAGES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, ry_by_n;

    int checks = 0;
    int failures = 0;
    int m_page = 0;
    int m_col = 0;
    int m_area = 0;

    always #2.5 clk = ~clk;

    nand_page_reader #(.PAGE_W(2), .TR(TRB)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .ry_by_n(ry_by_n)
    );

    function automatic int exp_byte(int pg, int col);
        return (col % 256 + (col / 256) * 37 + pg * 101) % 256;
    endfunction

    function automatic int start_of(int area, int b);
        if (area == 1) return 256 + b;
        if (area == 2) return 512 + (b % 16);
        return b;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(output int busy);
        busy = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!ry_by_n) busy++;
            else if (busy > 0 || i >= 2) break;
        end
    endtask

    task automatic wr_byte(logic c, logic a, logic [7:0] b, output int busy);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk); @(negedge clk);
        we_n = 1'b1;
        settle(busy);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic open_read(string tag, int cmd, int col, int pg);
        int busy;
        ce_n = 1'b0;
        if (cmd >= 0) begin
            wr_byte(1'b1, 1'b0, 8'(cmd), busy);
            m_area = (cmd == 8'h01) ? 1 : (cmd == 8'h50) ? 2 : 0;
        end
        wr_byte(1'b0, 1'b1, 8'(col), busy);
        wr_byte(1'b0, 1'b1, 8'(pg), busy);
        chk({tag, " R9 address busy length"}, busy, TRB);
        m_col = start_of(m_area, col);
        m_page = pg % PAGES;
    endtask

    task automatic rd(string tag);
        int busy;
        re_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk({tag, " R6 io_oe"}, int'(io_oe), 1);
        chk({tag, " data"}, int'(io_out), exp_byte(m_page, m_col));
        re_n = 1'b1;
        settle(busy);
        if (m_col == 527) begin
            chk({tag, " R9 page load busy length"}, busy, TRB);
            m_page = (m_page + 1) % PAGES;
            m_col = (m_area == 2) ? 512 : 0;
            if (m_area == 1) m_area = 0;
        end else begin
            m_col++;
        end
    endtask

    initial begin
        #(150000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int busy;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ry_by_n", int'(ry_by_n), 1);
        chk("R1 io_oe", int'(io_oe), 0);
        chk("R1 io_out", int'(io_out), 0);

        open_read("R2", 8'h00, 8'h10, 1);
        repeat (4) rd("R2");

        open_read("R3", 8'h01, 8'h05, 2);
        repeat (3) rd("R3");

        open_read("R4", 8'h50, 8'hA7, 3);
        chk("R4 start column", m_col, 519);
        repeat (3) rd("R4");

        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        open_read("R5 lock", -1, 8'h03, 0);
        chk("R5 lock start column", m_col, 515);
        rd("R5 lock");
        open_read("R5 release", 8'h00, 8'h03, 0);
        rd("R5 release");

        open_read("R7", 8'h01, 8'hFF, 3);
        repeat (17) rd("R7");
        chk("R7 next column", m_col, 0);
        chk("R6 page wrap", m_page, 0);
        repeat (2) rd("R7 R6 after wrap");

        open_read("R8", 8'h50, 8'hFE, 1);
        repeat (2) rd("R8");
        chk("R8 next column", m_col, 512);
        repeat (2) rd("R8 after page");

        // R9: read strobes during the load are ignored
        ce_n = 1'b0;
        wr_byte(1'b1, 1'b0, 8'h00, busy);
        m_area = 0;
        wr_byte(1'b0, 1'b1, 8'h20, busy);
        cle = 1'b0; ale = 1'b1; io_in = 8'h00; we_n = 1'b0;
        @(negedge clk); @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        re_n = 1'b0;
        @(negedge clk);
        chk("R9 busy during load", int'(ry_by_n), 0);
        chk("R9 io_oe during load", int'(io_oe), 0);
        re_n = 1'b1;
        settle(busy);
        m_col = 32; m_page = 0;
        rd("R9 pointer unmoved");

        // R10: chip enable high ends the read
        rd("R10 before");
        ce_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 io_oe", int'(io_oe), 0);
        chk("R10 ry_by_n", int'(ry_by_n), 1);
        re_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 io_oe on strobe", int'(io_oe), 0);
        re_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int t = 0; t < 10; t++) begin
            int sel = int'($urandom % 3);
            int cmd = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : 8'h50;
            int n = 1 + int'($urandom % 6);
            open_read("random R2 R3 R4", cmd, int'($urandom % 256), int'($urandom % 4));
            for (int k = 0; k < n; k++) rd("random R6");
            ce_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule